// File: doc/BRIEF.md
# Bus Output Latch Port

This block is a single 8-bit write/read register that sits on the bus of a classic 8-bit microprocessor. The processor uses a two-phase clock. The bus carries a 16-bit address, an 8-bit data path, a read/write line that is high for reads, and the phase-2 clock. The block runs on a faster system clock and samples phase 2 through a synchronizer. The address, data and read/write lines pass through the same number of flops, so every bus field stays aligned with the synchronized phase 2. All control is synchronous.

A small cycle state machine classifies each phase-2-high interval by the address decode and the read/write line:

- `ST_IDLE`: phase 2 is low.
- `ST_READ`: a read of this location is in progress.
- `ST_WRITE`: a write to this location is in progress.
- `ST_OTHER`: phase 2 is high, but the access is not for this location.

The transitions are:

- `go_read`, `go_write` and `go_other`: taken from `ST_IDLE` when synchronized phase 2 is high. The three high states also re-classify on every cycle while phase 2 stays high.
- `end_cycle`: taken from any high state back to `ST_IDLE` once the falling edge of phase 2 is detected. When this transition leaves `ST_WRITE`, it fires the write strobe.

The strobe loads the bus data held at that edge into the register. The register drives a parallel output port at all times. During a read of the location, the block raises an output enable and presents the stored value on its data output.

The location is a full decode. Address bits [15:8] must equal a base page parameter, and bit 15 of that page picks the upper or lower 32K half. Bits [7:0] must equal an offset parameter.

Top module: `bus_latch_port`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, `port_out` becomes 8'h00 and `data_oe` becomes 0 after that edge.
- R2: A location hit requires `addr[15:8] == BASE_PAGE` and `addr[7:0] == REG_OFFSET`. With the defaults 8'hC0 and 8'h10, this is 16'hC010 in the upper 32K half. A write cycle to any other address leaves `port_out` unchanged, including 16'h4010, which differs only in bit 15.
- R3: In a write cycle to the location (`rw` = 0 while `phi2` is high), the register stores the `data_in` value present when `phi2` falls. Data driven earlier in the high phase is overwritten by later values. Data changed at or after the fall is ignored.
- R4: A read cycle to the location (`rw` = 1) never changes `port_out`.
- R5: After a qualifying write, `port_out` still holds the old value after the second rising `clk` edge that follows the fall of `phi2`. It shows the new value after the third edge, which is one clock after the fall is detected.
- R6: During a read cycle to the location, `data_oe` is 1 by the third rising edge after `phi2` rises, and `data_out` equals the stored value. Whenever `data_oe` is 0, `data_out` is 8'h00.
- R7: `data_oe` stays 0 in write cycles, in cycles for other addresses and while `phi2` is low. After a read it returns to 0 by the third rising edge after `phi2` falls.
- R8: Bus activity while `phi2` stays low does not change `port_out`, even a matching address with `rw` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Processor phase-2 clock, asynchronous to `clk` |
| addr | input | 16 | Processor address bus |
| data_in | input | 8 | Processor write data |
| rw | input | 1 | Read/write line, 1 = read, 0 = write |
| data_out | output | 8 | Readback data, 8'h00 when not enabled |
| data_oe | output | 1 | Readback output enable |
| port_out | output | 8 | Stored register, parallel output to the system |

## Verification
The bench changes the write data in the middle of the high phase and again on the very cycle that phase 2 falls. A design that captured on select rather than on the falling edge would store the early value. A design that was not delay-matched would store the late garbage value. The bench checks the output port one edge before and one edge at the expected update, so a strobe that is early or late by a cycle is caught. Writes to an address that differs only in bit 15, reads of the location, and matching writes made while phase 2 stays low must all leave the register untouched. Read and write cycles also check the output enable, which catches a decode that ignores phase 2 or the read/write line.

// File: rtl/bl_pkg.sv
package bl_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PAGE_W = ADDR_W / 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              rw;
    } bus_sample_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_OTHER = 2'd3
    } cyc_state_t;
endpackage

// File: rtl/bl_phase_sync.sv
module bl_phase_sync
    import bl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        phi2,
    input  bus_sample_t bus_in,
    output logic        phi2_s,
    output logic        phi2_fall,
    output bus_sample_t bus_now,
    output bus_sample_t bus_held
);
    logic [STAGES-1:0] phi_chain;
    bus_sample_t       bus_chain [STAGES];
    logic              phi2_prev;

    // Phase 2 and the bus fields travel through equal-length chains.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                phi_chain[g] <= 1'b0;
                bus_chain[g] <= '0;
            end else if (g == 0) begin
                phi_chain[g] <= phi2;
                bus_chain[g] <= bus_in;
            end else begin
                phi_chain[g] <= phi_chain[g-1];
                bus_chain[g] <= bus_chain[g-1];
            end
        end
    end

    assign phi2_s    = phi_chain[STAGES-1];
    assign bus_now   = bus_chain[STAGES-1];
    assign phi2_fall = phi2_prev & ~phi2_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            phi2_prev <= 1'b0;
            bus_held  <= '0;
        end else begin
            phi2_prev <= phi2_s;
            if (phi2_s) begin
                bus_held <= bus_now;
            end
        end
    end
endmodule

// File: rtl/bl_addr_match.sv
module bl_addr_match
    import bl_pkg::*;
#(
    parameter logic [PAGE_W-1:0] BASE_PAGE  = 8'hC0,
    parameter logic [PAGE_W-1:0] REG_OFFSET = 8'h10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic page_ok;
    logic offs_ok;

    // The page top bit selects the upper or lower 32K half.
    assign page_ok = (addr[ADDR_W-1:PAGE_W] == BASE_PAGE);
    assign offs_ok = (addr[PAGE_W-1:0] == REG_OFFSET);
    assign hit     = page_ok & offs_ok;
endmodule

// File: rtl/bl_cycle_fsm.sv
module bl_cycle_fsm
    import bl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic phi2_s,
    input  logic phi2_fall,
    input  logic hit,
    input  logic rw,
    output logic write_strobe,
    output logic read_en
);
    cyc_state_t state_q;
    cyc_state_t state_d;
    cyc_state_t classed;

    always_comb begin
        if (!hit)    classed = ST_OTHER;
        else if (rw) classed = ST_READ;
        else         classed = ST_WRITE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (phi2_s) state_d = classed;
            end
            ST_READ, ST_WRITE, ST_OTHER: begin
                if (!phi2_s) state_d = ST_IDLE;
                else         state_d = classed;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        write_strobe = 1'b0;
        read_en      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ:  read_en = 1'b1;
            ST_WRITE: write_strobe = phi2_fall;
            ST_OTHER: ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/bus_latch_port.sv
module bus_latch_port
    import bl_pkg::*;
#(
    parameter logic [7:0] BASE_PAGE   = 8'hC0,
    parameter logic [7:0] REG_OFFSET  = 8'h10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        phi2,
    input  logic [15:0] addr,
    input  logic [7:0]  data_in,
    input  logic        rw,
    output logic [7:0]  data_out,
    output logic        data_oe,
    output logic [7:0]  port_out
);
    bus_sample_t bus_in;
    bus_sample_t bus_now;
    bus_sample_t held;
    logic        phi2_s;
    logic        phi2_fall;
    logic        hit;
    logic        wr_stb;
    logic        rd_en;
    logic [DATA_W-1:0] store_q;

    assign bus_in = '{addr: addr, data: data_in, rw: rw};

    bl_phase_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .phi2      (phi2),
        .bus_in    (bus_in),
        .phi2_s    (phi2_s),
        .phi2_fall (phi2_fall),
        .bus_now   (bus_now),
        .bus_held  (held)
    );

    bl_addr_match #(.BASE_PAGE(BASE_PAGE), .REG_OFFSET(REG_OFFSET)) u_match (
        .addr (bus_now.addr),
        .hit  (hit)
    );

    bl_cycle_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .phi2_s       (phi2_s),
        .phi2_fall    (phi2_fall),
        .hit          (hit),
        .rw           (bus_now.rw),
        .write_strobe (wr_stb),
        .read_en      (rd_en)
    );

    always_ff @(posedge clk) begin
        if (rst)         store_q <= '0;
        else if (wr_stb) store_q <= held.data;
    end

    assign port_out = store_q;
    assign data_oe  = rd_en;
    assign data_out = rd_en ? store_q : '0;
endmodule

// File: rtl/bl_port_checker.sv
module bl_port_checker (
    input logic       clk,
    input logic       rst,
    input logic       phi2_s,
    input logic       phi2_fall,
    input logic       write_strobe,
    input logic       held_rw,
    input logic [7:0] held_data,
    input logic       data_oe,
    input logic [7:0] data_out,
    input logic [7:0] port_out
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (port_out == 8'h00) && !data_oe);

    p_strobe_is_write_r4: assert property (@(posedge clk) disable iff (rst)
        write_strobe |-> !held_rw);

    p_strobe_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        write_strobe |-> phi2_fall);

    p_capture_held_r3: assert property (@(posedge clk) disable iff (rst)
        write_strobe |=> port_out == $past(held_data));

    p_hold_unless_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        !write_strobe |=> $stable(port_out));

    p_oe_needs_phase_r7: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> $past(phi2_s));

    p_readback_value_r6: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> data_out == port_out);

    p_idle_bus_r6: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> data_out == 8'h00);

    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({write_strobe, data_oe}));
endmodule

bind bus_latch_port bl_port_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .phi2_s       (phi2_s),
    .phi2_fall    (phi2_fall),
    .write_strobe (wr_stb),
    .held_rw      (held.rw),
    .held_data    (held.data),
    .data_oe      (data_oe),
    .data_out     (data_out),
    .port_out     (port_out)
);

// File: tb/bus_latch_port_bench.sv
module bus_latch_port_bench;
    localparam int LOW_CLKS  = 30;
    localparam int HIGH_CLKS = 30;
    localparam logic [15:0] HOME = 16'hC010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi2 = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  data_in = 8'h00;
    logic        rw = 1'b1;
    logic [7:0]  data_out;
    logic        data_oe;
    logic [7:0]  port_out;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model = 8'h00;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t exp_q[$];
    event cyc_done;
    bit   done = 0;

    always #4 clk = ~clk;

    bus_latch_port u_bus_latch_port (
        .clk      (clk),
        .rst      (rst),
        .phi2     (phi2),
        .addr     (addr),
        .data_in  (data_in),
        .rw       (rw),
        .data_out (data_out),
        .data_oe  (data_oe),
        .port_out (port_out)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp,
                         input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: compares the port against queued expectations.
    initial begin
        forever begin
            @(cyc_done);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(port_out, e.val, e.req, "port after cycle");
            end
        end
    end

    // One full bus cycle. d_early is driven first; d_final just before the fall.
    task automatic bus_cycle(input logic [15:0] a, input logic r,
                             input logic [7:0] d_early, input logic [7:0] d_final,
                             input string req);
        logic hitw;
        logic hitr;
        logic [7:0] old;
        hitw = (a == HOME) && !r;
        hitr = (a == HOME) && r;
        old  = model;
        @(negedge clk);
        phi2 = 1'b0; addr = a; rw = r; data_in = d_early;
        repeat (LOW_CLKS) @(negedge clk);
        phi2 = 1'b1;
        repeat (HIGH_CLKS / 2) @(negedge clk);
        // R6 / R7: enable only on reads of the location
        check({7'd0, data_oe}, {7'd0, hitr}, hitr ? "R6" : "R7", "oe mid-high");
        check(data_out, hitr ? model : 8'h00, "R6", "readback data");
        data_in = d_final;
        repeat (HIGH_CLKS / 2) @(negedge clk);
        phi2 = 1'b0;
        data_in = 8'hEE;   // R3: change at the fall must be ignored
        @(posedge clk); @(posedge clk); #1;
        check(port_out, old, "R5", "before third edge");
        @(posedge clk); #1;
        if (hitw) model = d_final;
        check(port_out, model, "R5", "at third edge");
        check({7'd0, data_oe}, 8'h00, "R7", "oe after fall");
        exp_q.push_back('{val: model, req: req});
        -> cyc_done;
        repeat (4) @(negedge clk);
        addr = 16'h0000; rw = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(port_out, 8'h00, "R1", "reset port");
        check({7'd0, data_oe}, 8'h00, "R1", "reset oe");
        rst = 1'b0;
        repeat (4) @(negedge clk);

        bus_cycle(HOME, 1'b0, 8'h11, 8'h5A, "R3");
        bus_cycle(HOME, 1'b1, 8'h00, 8'hFF, "R4");
        bus_cycle(16'h4010, 1'b0, 8'h22, 8'h99, "R2");
        bus_cycle(16'hC011, 1'b0, 8'h33, 8'h77, "R2");
        bus_cycle(16'hC110, 1'b0, 8'h44, 8'h66, "R2");
        bus_cycle(HOME, 1'b0, 8'h0F, 8'hA5, "R3");
        bus_cycle(HOME, 1'b1, 8'h01, 8'h02, "R6");
        bus_cycle(16'h4010, 1'b1, 8'h01, 8'h02, "R7");

        // R8: matching write activity with phase 2 held low
        @(negedge clk);
        phi2 = 1'b0; addr = HOME; rw = 1'b0;
        for (int i = 0; i < 10; i++) begin
            data_in = 8'(i * 17);
            @(negedge clk);
        end
        repeat (5) @(negedge clk);
        check(port_out, model, "R8", "phase-2 low activity");

        bus_cycle(HOME, 1'b0, 8'hFF, 8'h00, "R3");
        bus_cycle(HOME, 1'b1, 8'h10, 8'h20, "R6");

        // R1: reset in operation clears the register
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        model = 8'h00;
        check(port_out, 8'h00, "R1", "reset mid-run");
        rst = 1'b0;
        repeat (5) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule